// File: doc/BRIEF.md
# Word-Addressed Data Memory with Read Gating

This block is the data store of a simple processor datapath. It holds 512 words of 32 bits. The processor presents a full 32-bit byte-free word address, but only the low nine bits pick an entry. Any two addresses that match in those nine bits reach the same word, so the upper address space folds onto the same storage.

A write happens at the rising clock edge when the write enable is high. A read needs no clock: the output follows the addressed word through combinational logic. The output is forced to all zeros whenever the read enable is low, so downstream logic sees a clean zero on cycles that do not load.

Internally a thin top joins two parts. A control part turns the enables into a small struct of strobes and extracts the word index. A datapath part holds the array, performs the write, and gates the read.

Top module: `word_data_mem`

## Requirements
- R1: Storage holds 512 independent 32-bit words, and `addr[8:0]` is the word index that selects one of them.
- R2: Address bits 31 down to 9 have no effect. Two addresses with equal `addr[8:0]` reach the same word for both writes and reads.
- R3: When `wrEn` is 1 at a rising edge of `clk`, `wrData` is stored into the word that `addr[8:0]` selects.
- R4: The read path has no clock. With `rdEn` at 1, `rdData` follows a change of `addr` without any clock edge.
- R5: When `rdEn` is 0, `rdData` is 32'h00000000 whatever the address and the stored contents are.
- R6: When reading and writing the same word in one cycle, `rdData` shows the old word before the rising edge and the new word right after it.
- R7: When `wrEn` is 0 at a rising edge, no stored word changes, even if `wrData` and `addr` are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| addr | input | 32 | Word address; only bits 8:0 are decoded |
| wrData | input | 32 | Word to be stored |
| wrEn | input | 1 | Write enable, sampled at the rising edge |
| rdEn | input | 1 | Read enable; 0 forces the output to zero |
| rdData | output | 32 | Combinational read result, gated by `rdEn` |

## Verification
The hardest case to reach from the ports is a read and a write to the same word in one cycle. The old word must be visible just before the edge and the new word just after it. The bench drives its inputs on the falling edge. It samples once shortly after that, then again one time unit after the rising edge, so both sides of the update are observed within the same cycle. Aliasing is reached by first filling every word. Each word is then read back through addresses whose upper 23 bits differ from those used to write it.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int ADDR_W_DEF = 32;
  localparam int DATA_W_DEF = 32;
  localparam int IDX_W_DEF  = 9;

  typedef struct packed {
    logic commit;  // store the write word at the next rising edge
    logic expose;  // pass the addressed word to the output
  } memStrobe_t;
endpackage

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
  import wdm_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int IDX_W  = IDX_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output memStrobe_t        strobes,
  output logic [IDX_W-1:0]  wordIdx
);
  // Upper address bits alias onto the same entries; fold them away.
  logic unusedUpperAddr;
  assign unusedUpperAddr = ^addr[ADDR_W-1:IDX_W];

  assign wordIdx = addr[IDX_W-1:0];

  always_comb begin
    strobes        = '0;
    strobes.commit = wrEn;
    strobes.expose = rdEn;
  end
endmodule

// File: rtl/wdm_store.sv
module wdm_store
  import wdm_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int IDX_W  = IDX_W_DEF
) (
  input  logic              clk,
  input  memStrobe_t        strobes,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [DATA_W-1:0] rawWord;

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      memArray[wordIdx] <= wrData;
    end
  end

  assign rawWord = memArray[wordIdx];

  // Per-bit output gate: zero unless the read is enabled.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rdGate
    assign rdData[b] = rawWord[b] & strobes.expose;
  end
endmodule

// File: rtl/word_data_mem.sv
module word_data_mem
  import wdm_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int IDX_W  = IDX_W_DEF
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData
);
  memStrobe_t       strobes;
  logic [IDX_W-1:0] wordIdx;

  wdm_ctrl #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) i_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobes(strobes),
    .wordIdx(wordIdx)
  );

  wdm_store #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) i_store (
    .clk    (clk),
    .strobes(strobes),
    .wordIdx(wordIdx),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/wdm_checker.sv
module wdm_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 9
) (
  input logic              clk,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData
);
  // The block has no reset; checks arm after the first rising edge.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic [IDX_W-1:0] idx;
  assign idx = addr[IDX_W-1:0];

  AST_RD_OFF_ZERO: assert property (@(negedge clk) disable iff (!armed)
    !rdEn |-> (rdData === '0)) else $error("read gate open while disabled"); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed)
    wrEn |=> (!(rdEn && idx == $past(idx)) || rdData === $past(wrData)))
    else $error("written word not visible"); // R3

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (!wrEn && rdEn) |=> (!(rdEn && idx == $past(idx)) || rdData === $past(rdData)))
    else $error("word changed without write enable"); // R7

  AST_SAME_ENTRY_OLD: assert property (@(posedge clk) disable iff (!armed)
    (wrEn && rdEn && $stable(addr) && $past(!wrEn) && $past(rdEn)) |-> rdData === $past(rdData))
    else $error("pre-edge read not the old word"); // R6
endmodule

bind word_data_mem wdm_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .IDX_W (IDX_W)
) i_wdm_checker (
  .clk   (clk),
  .addr  (addr),
  .wrData(wrData),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .rdData(rdData)
);

// File: tb/test_word_data_mem.sv
`timescale 1ns/1ps
module test_word_data_mem;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] model [DEPTH];

  always #5 clk = ~clk;

  word_data_mem i_word_data_mem (
    .clk(clk), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [31:0] a;
    logic [31:0] d;
  } vec_t;

  // Mixed operations after the fill; expected values come from the model.
  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b1, 32'h0000_0005, 32'hDEAD_BEEF},
    '{1'b0, 1'b1, 32'hFFFF_FE05, 32'h0000_0000},
    '{1'b1, 1'b0, 32'h8000_01FF, 32'h1234_5678},
    '{1'b0, 1'b1, 32'h0000_01FF, 32'h0000_0000},
    '{1'b0, 1'b0, 32'h0000_01FF, 32'hFFFF_FFFF},
    '{1'b1, 1'b1, 32'h7FFF_FE00, 32'hCAFE_F00D},
    '{1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 1'b1, 32'h0000_0100, 32'h5555_5555},
    '{1'b1, 1'b1, 32'h0000_0100, 32'h0F0F_0F0F},
    '{1'b0, 1'b1, 32'hABCD_E100, 32'h0000_0000}
  };

  function automatic logic [31:0] pattern(input int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E37_79B1;
    return v ^ 32'hA5A5_0000 ^ 32'(i);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; checks before and after the next rising edge.
  task automatic step(input logic wr, input logic rd, input logic [31:0] a,
                      input logic [31:0] d, input string req);
    wrEn = wr; rdEn = rd; addr = a; wrData = d;
    #2;
    check(rdData, rd ? model[a[8:0]] : 32'h0, req);
    @(posedge clk);
    if (wr) model[a[8:0]] = d;
    #1;
    check(rdData, rd ? model[a[8:0]] : 32'h0, req);
    @(negedge clk);
  endtask

  initial begin
    #1;
    check(rdData, 32'h0, "R5 initial output with read disabled");
    @(negedge clk);

    // R1 R3 R5: fill all words, read disabled, output must stay zero.
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, {23'(i * 7 + 3), 9'(i)}, pattern(i), "R5 fill with read off");
    end

    // R1 R2: read each word through different upper bits.
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, {~23'(i * 13), 9'(i)}, 32'h0, "R2 alias read back");
    end

    // Table walk.
    for (int k = 0; k < 10; k++) begin
      step(VEC[k].wr, VEC[k].rd, VEC[k].a, VEC[k].d, "R6 table vector");
    end

    // R7: write enable low, data driven, word must remain.
    step(1'b0, 1'b0, 32'h0000_0042, 32'hBAD0_BAD0, "R7 disabled write");
    step(1'b0, 1'b1, 32'h0000_0042, 32'h0, "R7 word unchanged");
    check(rdData, pattern(32'h42), "R7 original word kept");

    // R6: read and write same word; old before edge, new after.
    wrEn = 1'b1; rdEn = 1'b1; addr = 32'h0000_0077; wrData = 32'h0BAD_CAFE;
    #2;
    check(rdData, pattern(32'h77), "R6 old word before edge");
    @(posedge clk); #1;
    check(rdData, 32'h0BAD_CAFE, "R6 new word after edge");
    model[9'h77] = 32'h0BAD_CAFE;
    @(negedge clk);
    wrEn = 1'b0;

    // R4: address changes with no clock edge in between.
    rdEn = 1'b1; addr = 32'h0000_0010; #1;
    check(rdData, model[9'h10], "R4 comb read first address");
    addr = 32'h0000_0011; #1;
    check(rdData, model[9'h11], "R4 comb read second address");
    rdEn = 1'b0; #1;
    check(rdData, 32'h0, "R5 gate closes without clock");

    // R2: write through high alias, read through another.
    @(negedge clk);
    step(1'b1, 1'b0, 32'hFFFF_FE33, 32'h1357_9BDF, "R2 alias write");
    step(1'b0, 1'b1, 32'h0000_0033, 32'h0, "R2 alias hit");
    check(rdData, 32'h1357_9BDF, "R2 aliased word value");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule